// File: doc/BRIEF.md
# Host Root Port Status and Wake Logic

This block holds the status and change flags of a single host root port and decides how they move when the port's line logic reports an attach, a detach, an over-current condition or a resume signal from downstream. Each reaction is qualified by the port's present state, which is supplied by the port control logic. A global port-change-detect flag collects every change. That flag, gated by an interrupt enable, forms the interrupt request.

Separate wake enables for attach, detach and over-current decide whether the matching event also raises a power-management wake request. The wake enables have no influence on the status bits themselves. Software clears change flags by writing ones through a clear strobe, and acknowledges a wake request on its own input.

Top module: `usb_rootport_wake`

## Requirements
- R1: A resume pulse while the port state is not suspended (state code 2'b01 disabled, 2'b10 enabled or 2'b00 detached) changes no output.
- R2: A resume pulse while the port state is suspended (2'b11) sets force_resume_o and port_chg_det_o on the following clock edge.
- R3: A detach pulse while the state is 2'b01, 2'b10 or 2'b11 clears conn_sts_o and port_en_o and sets conn_chg_o and port_chg_det_o on the next edge. In state 2'b00 it is ignored.
- R4: An attach pulse in state 2'b00 sets conn_sts_o, conn_chg_o and port_chg_det_o on the next edge. In any other state it is ignored.
- R5: A rising edge of overcurrent_i while the state is not 2'b00 sets oc_chg_o and port_chg_det_o and clears port_en_o on the next edge. In state 2'b00 it sets no change flag.
- R6: oc_act_o equals overcurrent_i delayed by one clock, whatever the port state.
- R7: Status updates are the same whatever the wake enables are. wake_req_o is set only when the event that fired has its own wake enable at one.
- R8: irq_o is high exactly when port_chg_det_o and chg_int_en_i are both high, in the same cycle.
- R9: With clr_we_i high, each one in clr_bits_i clears one flag: bit 0 conn_chg_o, bit 1 oc_chg_o, bit 2 force_resume_o, bit 3 port_chg_det_o. Zero bits leave their flag unchanged. An event setting a flag in the same cycle wins over its clear.
- R10: Once set, wake_req_o stays high until a cycle with wake_ack_i high. A new wake event in that same cycle keeps it set.
- R11: enable_grant_i sets port_en_o on the next edge only while conn_sts_o is high. A same-cycle detach or over-current edge wins and leaves it clear.
- R12: After reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_state_i | input | 2 | Present port state: 00 detached, 01 disabled, 10 enabled, 11 suspended |
| connect_evt_i | input | 1 | Attach detected (one-cycle pulse) |
| disconnect_evt_i | input | 1 | Detach detected (one-cycle pulse) |
| overcurrent_i | input | 1 | Live over-current level |
| resume_k_i | input | 1 | Resume signalling received (one-cycle pulse) |
| enable_grant_i | input | 1 | Port enable granted by the port control logic (pulse) |
| wake_conn_en_i | input | 1 | Wake on attach enable |
| wake_disc_en_i | input | 1 | Wake on detach enable |
| wake_oc_en_i | input | 1 | Wake on over-current enable |
| chg_int_en_i | input | 1 | Port-change interrupt enable |
| clr_we_i | input | 1 | Write strobe for the clear mask |
| clr_bits_i | input | 4 | Write-one-to-clear mask for the change flags |
| wake_ack_i | input | 1 | Software acknowledge of the wake request |
| conn_sts_o | output | 1 | Device attached |
| conn_chg_o | output | 1 | Attach state changed |
| port_en_o | output | 1 | Port enabled |
| oc_act_o | output | 1 | Over-current present |
| oc_chg_o | output | 1 | Over-current seen |
| force_resume_o | output | 1 | Resume being driven on the port |
| port_chg_det_o | output | 1 | Global port change detected |
| irq_o | output | 1 | Interrupt request |
| wake_req_o | output | 1 | Power-management wake request |

## Verification
The bench sends every event into the states where it must be ignored as well as the states where it acts. A design that forgot the state qualification would flag a resume on a disabled port, or a detach on an empty port. It holds over-current high across a clear of its change flag, so a design that set the flag on the level rather than on the edge would show the flag again at once. It writes a zero mask, then one-bit masks, and a full mask in the same cycle as an attach. A design with the wrong bit map or with clear given priority over set would lose a flag or clear the wrong one. It drives events with their wake enable low and high, and holds the wake request for several cycles before the acknowledge. This catches wake logic that is ungated or that drops the request by itself.

// File: rtl/rpw_pkg.sv
package rpw_pkg;
  typedef enum logic [1:0] {
    PS_DETACHED  = 2'b00,
    PS_DISABLED  = 2'b01,
    PS_ENABLED   = 2'b10,
    PS_SUSPENDED = 2'b11
  } port_state_e;

  localparam int CHG_N       = 4;
  localparam int IDX_CONN    = 0;
  localparam int IDX_OC      = 1;
  localparam int IDX_RESUME  = 2;
  localparam int IDX_PCD     = 3;

  // A port counts as attached in every state except detached.
  function automatic logic is_attached(port_state_e s);
    return s != PS_DETACHED;
  endfunction

  // Sticky flag: set dominates clear.
  function automatic logic sticky_next(logic q, logic set, logic clr);
    return set | (q & ~clr);
  endfunction

  // Enable bit: loss events dominate a grant; a grant needs an attached device.
  function automatic logic enable_next(logic q, logic lose, logic grant, logic attached);
    if (lose) return 1'b0;
    if (grant && attached) return 1'b1;
    return q;
  endfunction
endpackage

// File: rtl/rpw_event_qual.sv
module rpw_event_qual
  import rpw_pkg::*;
(
  input  port_state_e state_i,
  input  logic        connect_i,
  input  logic        disconnect_i,
  input  logic        oc_live_i,
  input  logic        oc_prev_i,
  input  logic        resume_i,
  output logic        conn_hit_o,
  output logic        disc_hit_o,
  output logic        oc_hit_o,
  output logic        resume_hit_o
);
  always_comb begin
    conn_hit_o   = connect_i    && (state_i == PS_DETACHED);
    disc_hit_o   = disconnect_i && is_attached(state_i);
    oc_hit_o     = oc_live_i && !oc_prev_i && is_attached(state_i);
    resume_hit_o = resume_i     && (state_i == PS_SUSPENDED);
  end
endmodule

// File: rtl/rpw_change_bits.sv
module rpw_change_bits
  import rpw_pkg::*;
#(
  parameter int N = CHG_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o[g] <= 1'b0;
      else        q_o[g] <= sticky_next(q_o[g], set_i[g], clr_i[g]);
    end
  end
endmodule

// File: rtl/rpw_wake_req.sv
module rpw_wake_req
  import rpw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic conn_hit_i,
  input  logic disc_hit_i,
  input  logic oc_hit_i,
  input  logic wk_conn_en_i,
  input  logic wk_disc_en_i,
  input  logic wk_oc_en_i,
  input  logic ack_i,
  output logic wake_set_o,
  output logic wake_o
);
  assign wake_set_o = (conn_hit_i & wk_conn_en_i) |
                      (disc_hit_i & wk_disc_en_i) |
                      (oc_hit_i   & wk_oc_en_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_o <= 1'b0;
    else        wake_o <= sticky_next(wake_o, wake_set_o, ack_i);
  end
endmodule

// File: rtl/usb_rootport_wake.sv
module usb_rootport_wake
  import rpw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        port_state_i,
  input  logic              connect_evt_i,
  input  logic              disconnect_evt_i,
  input  logic              overcurrent_i,
  input  logic              resume_k_i,
  input  logic              enable_grant_i,
  input  logic              wake_conn_en_i,
  input  logic              wake_disc_en_i,
  input  logic              wake_oc_en_i,
  input  logic              chg_int_en_i,
  input  logic              clr_we_i,
  input  logic [CHG_N-1:0]  clr_bits_i,
  input  logic              wake_ack_i,
  output logic              conn_sts_o,
  output logic              conn_chg_o,
  output logic              port_en_o,
  output logic              oc_act_o,
  output logic              oc_chg_o,
  output logic              force_resume_o,
  output logic              port_chg_det_o,
  output logic              irq_o,
  output logic              wake_req_o
);
  port_state_e      state;
  logic             conn_hit, disc_hit, oc_hit, resume_hit;
  logic             any_change, wake_set;
  logic             oc_q, conn_q, en_q;
  logic [CHG_N-1:0] chg_set, chg_clr, chg_q;

  assign state = port_state_e'(port_state_i);

  rpw_event_qual u_qual (
    .state_i      (state),
    .connect_i    (connect_evt_i),
    .disconnect_i (disconnect_evt_i),
    .oc_live_i    (overcurrent_i),
    .oc_prev_i    (oc_q),
    .resume_i     (resume_k_i),
    .conn_hit_o   (conn_hit),
    .disc_hit_o   (disc_hit),
    .oc_hit_o     (oc_hit),
    .resume_hit_o (resume_hit)
  );

  assign any_change = conn_hit | disc_hit | oc_hit | resume_hit;

  always_comb begin
    chg_set             = '0;
    chg_set[IDX_CONN]   = conn_hit | disc_hit;
    chg_set[IDX_OC]     = oc_hit;
    chg_set[IDX_RESUME] = resume_hit;
    chg_set[IDX_PCD]    = any_change;
    chg_clr             = clr_we_i ? clr_bits_i : '0;
  end

  rpw_change_bits #(.N(CHG_N)) u_chg (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (chg_set),
    .clr_i (chg_clr),
    .q_o   (chg_q)
  );

  rpw_wake_req u_wake (
    .clk          (clk),
    .rst_n        (rst_n),
    .conn_hit_i   (conn_hit),
    .disc_hit_i   (disc_hit),
    .oc_hit_i     (oc_hit),
    .wk_conn_en_i (wake_conn_en_i),
    .wk_disc_en_i (wake_disc_en_i),
    .wk_oc_en_i   (wake_oc_en_i),
    .ack_i        (wake_ack_i),
    .wake_set_o   (wake_set),
    .wake_o       (wake_req_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_q   <= 1'b0;
      conn_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      oc_q <= overcurrent_i;
      if (disc_hit)      conn_q <= 1'b0;
      else if (conn_hit) conn_q <= 1'b1;
      en_q <= enable_next(en_q, disc_hit | oc_hit, enable_grant_i, conn_q);
    end
  end

  assign conn_sts_o     = conn_q;
  assign port_en_o      = en_q;
  assign oc_act_o       = oc_q;
  assign conn_chg_o     = chg_q[IDX_CONN];
  assign oc_chg_o       = chg_q[IDX_OC];
  assign force_resume_o = chg_q[IDX_RESUME];
  assign port_chg_det_o = chg_q[IDX_PCD];
  assign irq_o          = chg_q[IDX_PCD] & chg_int_en_i;
endmodule

// File: rtl/usb_rootport_wake_chk.sv
module usb_rootport_wake_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] port_state_i,
  input logic       connect_evt_i,
  input logic       disconnect_evt_i,
  input logic       overcurrent_i,
  input logic       resume_k_i,
  input logic       chg_int_en_i,
  input logic       clr_we_i,
  input logic       wake_ack_i,
  input logic       conn_sts_o,
  input logic       conn_chg_o,
  input logic       port_en_o,
  input logic       oc_act_o,
  input logic       oc_chg_o,
  input logic       force_resume_o,
  input logic       port_chg_det_o,
  input logic       irq_o,
  input logic       wake_req_o
);
  p_resume_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_k_i && port_state_i != 2'b11 && !clr_we_i) |=> $stable(force_resume_o));

  p_resume_susp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_k_i && port_state_i == 2'b11) |=> (force_resume_o && port_chg_det_o));

  p_detach_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (disconnect_evt_i && port_state_i != 2'b00) |=>
      (!conn_sts_o && !port_en_o && conn_chg_o && port_chg_det_o));

  p_attach_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (connect_evt_i && port_state_i == 2'b00) |=> (conn_sts_o && conn_chg_o && port_chg_det_o));

  p_oc_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (overcurrent_i && !oc_act_o && port_state_i != 2'b00) |=>
      (oc_chg_o && !port_en_o && port_chg_det_o));

  p_oc_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (oc_act_o == $past(overcurrent_i)));

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (chg_int_en_i && port_chg_det_o));

  p_wake_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req_o && !wake_ack_i) |=> wake_req_o);
endmodule

bind usb_rootport_wake usb_rootport_wake_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .port_state_i     (port_state_i),
  .connect_evt_i    (connect_evt_i),
  .disconnect_evt_i (disconnect_evt_i),
  .overcurrent_i    (overcurrent_i),
  .resume_k_i       (resume_k_i),
  .chg_int_en_i     (chg_int_en_i),
  .clr_we_i         (clr_we_i),
  .wake_ack_i       (wake_ack_i),
  .conn_sts_o       (conn_sts_o),
  .conn_chg_o       (conn_chg_o),
  .port_en_o        (port_en_o),
  .oc_act_o         (oc_act_o),
  .oc_chg_o         (oc_chg_o),
  .force_resume_o   (force_resume_o),
  .port_chg_det_o   (port_chg_det_o),
  .irq_o            (irq_o),
  .wake_req_o       (wake_req_o)
);

// File: tb/usb_rootport_wake_tb_top.sv
`timescale 1ns/1ps
module usb_rootport_wake_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] port_state = 2'b00;
  logic       connect_evt = 1'b0, disconnect_evt = 1'b0, overcurrent = 1'b0, resume_k = 1'b0;
  logic       enable_grant = 1'b0;
  logic       wk_conn = 1'b0, wk_disc = 1'b0, wk_oc = 1'b0, int_en = 1'b0;
  logic       clr_we = 1'b0;
  logic [3:0] clr_bits = 4'h0;
  logic       wake_ack = 1'b0;
  logic       conn_sts, conn_chg, port_en, oc_act, oc_chg, force_resume, pcd, irq, wake_req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [1:0] ST_DET = 2'b00, ST_DIS = 2'b01, ST_ENA = 2'b10, ST_SUS = 2'b11;

  always #4 clk = ~clk;

  usb_rootport_wake dut_i (
    .clk(clk), .rst_n(rst_n), .port_state_i(port_state),
    .connect_evt_i(connect_evt), .disconnect_evt_i(disconnect_evt),
    .overcurrent_i(overcurrent), .resume_k_i(resume_k), .enable_grant_i(enable_grant),
    .wake_conn_en_i(wk_conn), .wake_disc_en_i(wk_disc), .wake_oc_en_i(wk_oc),
    .chg_int_en_i(int_en), .clr_we_i(clr_we), .clr_bits_i(clr_bits), .wake_ack_i(wake_ack),
    .conn_sts_o(conn_sts), .conn_chg_o(conn_chg), .port_en_o(port_en), .oc_act_o(oc_act),
    .oc_chg_o(oc_chg), .force_resume_o(force_resume), .port_chg_det_o(pcd),
    .irq_o(irq), .wake_req_o(wake_req)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clear_all();
    clr_we = 1'b1; clr_bits = 4'hF;
    step();
    clr_we = 1'b0; clr_bits = 4'h0;
  endtask

  task automatic t_reset();
    chk("R12", "conn_sts", conn_sts, 1'b0);
    chk("R12", "conn_chg", conn_chg, 1'b0);
    chk("R12", "port_en",  port_en,  1'b0);
    chk("R12", "oc_chg",   oc_chg,   1'b0);
    chk("R12", "pcd",      pcd,      1'b0);
    chk("R12", "wake",     wake_req, 1'b0);
    chk("R12", "irq",      irq,      1'b0);
  endtask

  task automatic t_attach();
    port_state = ST_DET; wk_conn = 1'b0; connect_evt = 1'b1;
    step(); connect_evt = 1'b0;
    chk("R4", "conn_sts", conn_sts, 1'b1);
    chk("R4", "conn_chg", conn_chg, 1'b1);
    chk("R4", "pcd", pcd, 1'b1);
    chk("R7", "no wake with enable low", wake_req, 1'b0);
    chk("R8", "irq masked", irq, 1'b0);
    int_en = 1'b1; #1;
    chk("R8", "irq enabled", irq, 1'b1);
  endtask

  task automatic t_attach_ignored();
    clear_all();
    chk("R9", "conn_chg cleared", conn_chg, 1'b0);
    chk("R8", "irq drops with pcd", irq, 1'b0);
    port_state = ST_ENA; connect_evt = 1'b1;
    step(); connect_evt = 1'b0;
    chk("R4", "attach ignored conn_chg", conn_chg, 1'b0);
    chk("R4", "attach ignored pcd", pcd, 1'b0);
  endtask

  task automatic t_grant();
    enable_grant = 1'b1;
    step(); enable_grant = 1'b0;
    chk("R11", "port_en granted", port_en, 1'b1);
  endtask

  task automatic t_resume();
    port_state = ST_DIS; resume_k = 1'b1;
    step(); resume_k = 1'b0;
    chk("R1", "disabled resume force", force_resume, 1'b0);
    chk("R1", "disabled resume pcd", pcd, 1'b0);
    port_state = ST_SUS; resume_k = 1'b1;
    step(); resume_k = 1'b0;
    chk("R2", "force_resume", force_resume, 1'b1);
    chk("R2", "pcd", pcd, 1'b1);
    chk("R2", "port_en kept", port_en, 1'b1);
    clr_we = 1'b1; clr_bits = 4'b0000;
    step();
    chk("R9", "zero mask keeps force", force_resume, 1'b1);
    chk("R9", "zero mask keeps pcd", pcd, 1'b1);
    clr_bits = 4'b0100;
    step();
    chk("R9", "bit2 clears force", force_resume, 1'b0);
    chk("R9", "bit2 keeps pcd", pcd, 1'b1);
    clr_bits = 4'b1000;
    step();
    clr_we = 1'b0; clr_bits = 4'h0;
    chk("R9", "bit3 clears pcd", pcd, 1'b0);
  endtask

  task automatic t_overcurrent();
    port_state = ST_ENA; wk_oc = 1'b1; overcurrent = 1'b1;
    step();
    chk("R6", "oc_act follows", oc_act, 1'b1);
    chk("R5", "oc_chg", oc_chg, 1'b1);
    chk("R5", "port_en cleared", port_en, 1'b0);
    chk("R5", "pcd", pcd, 1'b1);
    chk("R7", "oc wake", wake_req, 1'b1);
    clr_we = 1'b1; clr_bits = 4'b0010;
    step();
    clr_we = 1'b0; clr_bits = 4'h0;
    step();
    chk("R5", "held level no retrigger", oc_chg, 1'b0);
    chk("R9", "bit1 keeps pcd", pcd, 1'b1);
    chk("R6", "oc_act while high", oc_act, 1'b1);
    overcurrent = 1'b0;
    step();
    chk("R6", "oc_act drops", oc_act, 1'b0);
  endtask

  task automatic t_wake_hold();
    wk_oc = 1'b0;
    repeat (3) step();
    chk("R10", "wake held", wake_req, 1'b1);
    wake_ack = 1'b1;
    step(); wake_ack = 1'b0;
    chk("R10", "wake acked", wake_req, 1'b0);
  endtask

  task automatic t_detach();
    clear_all();
    port_state = ST_SUS; wk_disc = 1'b0; disconnect_evt = 1'b1;
    step(); disconnect_evt = 1'b0;
    chk("R3", "conn_sts cleared", conn_sts, 1'b0);
    chk("R3", "port_en cleared", port_en, 1'b0);
    chk("R3", "conn_chg", conn_chg, 1'b1);
    chk("R3", "pcd", pcd, 1'b1);
    chk("R7", "no disc wake", wake_req, 1'b0);
    enable_grant = 1'b1;
    step(); enable_grant = 1'b0;
    chk("R11", "grant ignored detached", port_en, 1'b0);
  endtask

  task automatic t_oc_detached();
    clear_all();
    port_state = ST_DET; wk_oc = 1'b1; overcurrent = 1'b1;
    step();
    chk("R6", "oc_act detached", oc_act, 1'b1);
    chk("R5", "no oc_chg detached", oc_chg, 1'b0);
    chk("R5", "no pcd detached", pcd, 1'b0);
    chk("R7", "no wake detached", wake_req, 1'b0);
    overcurrent = 1'b0; wk_oc = 1'b0;
    step();
  endtask

  task automatic t_set_wins();
    port_state = ST_DET; wk_conn = 1'b1; connect_evt = 1'b1;
    clr_we = 1'b1; clr_bits = 4'hF;
    step();
    connect_evt = 1'b0; clr_we = 1'b0; clr_bits = 4'h0; wk_conn = 1'b0;
    chk("R9", "set beats clear conn_chg", conn_chg, 1'b1);
    chk("R9", "set beats clear pcd", pcd, 1'b1);
    chk("R7", "attach wake", wake_req, 1'b1);
    disconnect_evt = 1'b1;
    step(); disconnect_evt = 1'b0;
    chk("R3", "detach ignored when detached", conn_sts, 1'b1);
    port_state = ST_ENA; wk_disc = 1'b1; disconnect_evt = 1'b1; wake_ack = 1'b1;
    step(); disconnect_evt = 1'b0; wake_ack = 1'b0; wk_disc = 1'b0;
    chk("R10", "new event beats ack", wake_req, 1'b1);
    chk("R3", "detach from enabled", conn_sts, 1'b0);
  endtask

  initial begin
    repeat (3) step();
    chk("R12", "irq in reset", irq, 1'b0);
    rst_n = 1'b1;
    step();
    t_reset();
    t_attach();
    t_attach_ignored();
    t_grant();
    t_resume();
    t_overcurrent();
    t_wake_hold();
    t_detach();
    t_oc_detached();
    t_set_wins();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule